// File: doc/BRIEF.md
# Three-step ordinal read sequencer

This controller reads a three-bit value from a multi-level magnetic cell without comparing the cell against any absolute resistance. It takes up to three resistance samples of the same cell, each under a different rotating-field angle. It then works out the value from how those samples rank against one another. The analog parts (field generator, sample storage slots, sense amplifier) sit outside the block and are reached through request/acknowledge ports.

A read starts with a one-cycle clear strobe that returns every storage slot and both comparator inputs to the common reset level. Each step then requests a field angle and waits for its acknowledge. After the acknowledge the block waits a programmable settle time, strobes a capture into the slot for that step, and runs one or two comparisons. The first sample is ranked against a low and a high threshold. When it sits at either extreme level, the read finishes after that single step. In all other cases two more samples are taken and ranked pairwise, and the three pairwise outcomes are decoded into the result word. A one-cycle done pulse marks the end of every read.

Top module: `ordinal_read_seq`

## Requirements
- R1: During and after a synchronous reset, `field_req`, `cmp_req`, `capture`, `slot_clear`, `done` and `err` are low and `data_out` is 000.
- R2: `start` is accepted in idle only. The block then raises `slot_clear` for exactly one cycle before the first field request. Field requests carry `field_angle` 0 (116.9°), 1 (−141.4°) and 2 (−90.2°) in that order. Code 3 is never requested. The capture for step n uses `capture_slot` n−1.
- R3: `capture` rises for one cycle exactly `settle_cycles`+1 clock cycles after the clock edge that accepted `field_ack`.
- R4: `field_req` stays high with a stable angle until `field_ack`, and `cmp_req` stays high with a stable `cmp_pair` until `cmp_valid`. At most one of `field_req`, `cmp_req`, `capture` and `slot_clear` is high in any cycle.
- R5: Step 1 issues `cmp_pair` 0 (sample 1 against the low threshold) and then `cmp_pair` 1 (sample 1 against the high threshold). In every comparison, `cmp_result`=1 means the first operand is the greater.
- R6: A low-threshold result of 0 ends the read with 001, and this takes priority. Otherwise a high-threshold result of 1 ends the read with 110. Both cases use one field application and two comparisons.
- R7: A read that is not at an extreme level runs steps 2 and 3. Step 2 compares pair 2 (sample 1 against sample 2). Step 3 compares pair 3 (1 against 3) and then pair 4 (2 against 3). The read uses three field applications and five comparisons in all.
- R8: With c12, c13 and c23 the results of pairs 2, 3 and 4, a consistent ordering yields `data_out` = {c12, c23, c13}.
- R9: A cyclic ordering (c12=1,c23=1,c13=0 or c12=0,c23=0,c13=1) sets `err` and forces `data_out` to 000.
- R10: `done` is a one-cycle pulse. `data_out` and `err` stay valid from the done cycle until the next accepted start, which clears them.
- R11: A `start` pulse during a read has no effect: no second read, no extra done and no extra field request.
- R12: A synchronous reset in the middle of a read returns the block to idle, and a following read completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Read request, taken in idle |
| settle_cycles | input | SETTLE_W | Wait after field acknowledge before capture |
| slot_clear | output | 1 | Return slots and comparator inputs to reset level |
| field_req | output | 1 | Field application request |
| field_angle | output | 2 | Angle code of the requested field |
| field_ack | input | 1 | Field applied |
| capture | output | 1 | Store sensed voltage into a slot |
| capture_slot | output | 2 | Slot being written |
| cmp_req | output | 1 | Comparison request |
| cmp_pair | output | 3 | Operand pair for the sense amplifier |
| cmp_valid | input | 1 | Comparator result strobe |
| cmp_result | input | 1 | 1 when the first operand is greater |
| done | output | 1 | Read complete pulse |
| data_out | output | 3 | Decoded value |
| err | output | 1 | Cyclic, impossible ordering seen |

## Verification
A wrong step or comparison index in the controller shows up at once in the next handshake, as an off-sequence `field_angle` or `cmp_pair`. That handshake comes within a few cycles of the fault, well before `done`. A result bit latched into the wrong position appears only at `done`, as a wrong decoded word or a wrong early exit. The bench therefore ranks every read against values it derives itself from per-state sample levels. A faulty settle counter moves the capture strobe by whole cycles, which is measured against each field acknowledge.

// File: rtl/ordinal_read_pkg.sv
package ordinal_read_pkg;

  localparam int NUM_CMP  = 5;
  localparam int NUM_STEP = 3;
  localparam int CIDX_W   = $clog2(NUM_CMP);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_FIELD, ST_SETTLE, ST_CAPTURE, ST_CMP, ST_FINISH
  } seq_state_e;

  // comparison order equals pair code
  localparam logic [CIDX_W-1:0] PAIR_THR_LO = 3'd0;
  localparam logic [CIDX_W-1:0] PAIR_THR_HI = 3'd1;
  localparam logic [CIDX_W-1:0] PAIR_S1S2   = 3'd2;
  localparam logic [CIDX_W-1:0] PAIR_S1S3   = 3'd3;
  localparam logic [CIDX_W-1:0] PAIR_S2S3   = 3'd4;

  typedef struct packed {
    logic [2:0] word;
    logic       bad;
  } read_out_t;

  function automatic logic closes_step(input logic [CIDX_W-1:0] idx);
    return (idx == PAIR_THR_HI) || (idx == PAIR_S1S2) || (idx == PAIR_S2S3);
  endfunction

  function automatic logic extreme_level(input logic [NUM_CMP-1:0] r);
    return !r[PAIR_THR_LO] || r[PAIR_THR_HI];
  endfunction

  function automatic read_out_t decode_order(input logic [NUM_CMP-1:0] r);
    read_out_t o;
    logic c12, c13, c23;
    c12 = r[PAIR_S1S2];
    c13 = r[PAIR_S1S3];
    c23 = r[PAIR_S2S3];
    o.bad = 1'b0;
    if (!r[PAIR_THR_LO])      o.word = 3'b001;
    else if (r[PAIR_THR_HI])  o.word = 3'b110;
    else if ((c12 && c23 && !c13) || (!c12 && !c23 && c13)) begin
      o.word = 3'b000;
      o.bad  = 1'b1;
    end else                  o.word = {c12, c23, c13};
    return o;
  endfunction

endpackage

// File: rtl/ors_settle_timer.sv
module ors_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                expired
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ors_decode.sv
module ors_decode
  import ordinal_read_pkg::*;
(
  input  logic [NUM_CMP-1:0] results,
  output logic [2:0]         word,
  output logic               bad
);
  read_out_t dec;
  always_comb begin
    dec  = decode_order(results);
    word = dec.word;
    bad  = dec.bad;
  end
endmodule

// File: rtl/ors_ctrl.sv
module ors_ctrl
  import ordinal_read_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               field_ack,
  input  logic               cmp_valid,
  input  logic               cmp_result,
  input  logic               timer_expired,
  output logic               timer_load,
  output logic               slot_clear,
  output logic               field_req,
  output logic [1:0]         field_angle,
  output logic               capture,
  output logic [1:0]         capture_slot,
  output logic               cmp_req,
  output logic [2:0]         cmp_pair,
  output logic [NUM_CMP-1:0] res_next,
  output logic               start_evt,
  output logic               finish_evt,
  output logic               in_finish
);
  seq_state_e          state_q, state_d;
  logic [1:0]          step_q, step_d;
  logic [CIDX_W-1:0]   cidx_q, cidx_d;
  logic [NUM_CMP-1:0]  res_q;
  logic                cmp_fire;

  assign cmp_fire = (state_q == ST_CMP) && cmp_valid;

  always_comb begin
    res_next = res_q;
    if (cmp_fire) res_next[cidx_q] = cmp_result;
  end

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    cidx_d     = cidx_q;
    timer_load = 1'b0;
    start_evt  = 1'b0;
    finish_evt = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d   = ST_CLEAR;
        start_evt = 1'b1;
        step_d    = '0;
        cidx_d    = '0;
      end
      ST_CLEAR:   state_d = ST_FIELD;
      ST_FIELD: if (field_ack) begin
        state_d    = ST_SETTLE;
        timer_load = 1'b1;
      end
      ST_SETTLE:  if (timer_expired) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_CMP;
      ST_CMP: if (cmp_valid) begin
        cidx_d = cidx_q + 1'b1;
        if ((cidx_q == PAIR_THR_HI && extreme_level(res_next)) || cidx_q == PAIR_S2S3) begin
          state_d    = ST_FINISH;
          finish_evt = 1'b1;
        end else if (closes_step(cidx_q)) begin
          state_d = ST_FIELD;
          step_d  = step_q + 2'd1;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      cidx_q  <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cidx_q  <= cidx_d;
      res_q   <= start_evt ? '0 : res_next;
    end
  end

  assign slot_clear   = (state_q == ST_CLEAR);
  assign field_req    = (state_q == ST_FIELD);
  assign field_angle  = step_q;
  assign capture      = (state_q == ST_CAPTURE);
  assign capture_slot = step_q;
  assign cmp_req      = (state_q == ST_CMP);
  assign cmp_pair     = cidx_q;
  assign in_finish    = (state_q == ST_FINISH);
endmodule

// File: rtl/ordinal_read_seq.sv
module ordinal_read_seq
  import ordinal_read_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                slot_clear,
  output logic                field_req,
  output logic [1:0]          field_angle,
  input  logic                field_ack,
  output logic                capture,
  output logic [1:0]          capture_slot,
  output logic                cmp_req,
  output logic [2:0]          cmp_pair,
  input  logic                cmp_valid,
  input  logic                cmp_result,
  output logic                done,
  output logic [2:0]          data_out,
  output logic                err
);
  logic               timer_load, timer_expired;
  logic               start_evt, finish_evt, in_finish;
  logic [NUM_CMP-1:0] res_next;
  logic [2:0]         dec_word;
  logic               dec_bad;
  logic [2:0]         data_q;
  logic               err_q;

  ors_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(settle_cycles),
    .expired(timer_expired)
  );

  ors_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .field_ack(field_ack),
    .cmp_valid(cmp_valid), .cmp_result(cmp_result),
    .timer_expired(timer_expired), .timer_load(timer_load),
    .slot_clear(slot_clear), .field_req(field_req), .field_angle(field_angle),
    .capture(capture), .capture_slot(capture_slot), .cmp_req(cmp_req),
    .cmp_pair(cmp_pair), .res_next(res_next), .start_evt(start_evt),
    .finish_evt(finish_evt), .in_finish(in_finish)
  );

  ors_decode u_decode (.results(res_next), .word(dec_word), .bad(dec_bad));

  always_ff @(posedge clk) begin
    if (rst || start_evt) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (finish_evt) begin
      data_q <= dec_word;
      err_q  <= dec_bad;
    end
  end

  assign done     = in_finish;
  assign data_out = data_q;
  assign err      = err_q;
endmodule

// File: rtl/ors_checker.sv
module ors_checker #(
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                slot_clear,
  input logic                field_req,
  input logic [1:0]          field_angle,
  input logic                field_ack,
  input logic                capture,
  input logic [1:0]          capture_slot,
  input logic                cmp_req,
  input logic [2:0]          cmp_pair,
  input logic                cmp_valid,
  input logic                cmp_result,
  input logic                done,
  input logic [2:0]          data_out,
  input logic                err
);
  logic [SETTLE_W:0] since_ack;

  always_ff @(posedge clk) begin
    if (rst)                          since_ack <= '0;
    else if (field_req && field_ack)  since_ack <= '0;
    else if (since_ack != '1)         since_ack <= since_ack + 1'b1;
  end

  assert_field_hold_R4: assert property (@(posedge clk) disable iff (rst)
    field_req && !field_ack |=> field_req && $stable(field_angle));
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    cmp_req && !cmp_valid |=> cmp_req && $stable(cmp_pair));
  assert_one_req_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({field_req, cmp_req, capture, slot_clear}));
  assert_angle_code_R2: assert property (@(posedge clk) disable iff (rst)
    field_req |-> field_angle != 2'd3);
  assert_settle_R3: assert property (@(posedge clk) disable iff (rst)
    capture |-> since_ack == ({1'b0, settle_cycles} + 1'b1));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> done || slot_clear);
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> data_out == 3'b000);
endmodule

bind ordinal_read_seq ors_checker #(.SETTLE_W(SETTLE_W)) u_chk (.*);

// File: tb/ordinal_read_seq_tb.sv
module ordinal_read_seq_tb;
  localparam int SW = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [SW-1:0] settle = 8'd3;
  logic field_ack = 1'b0, cmp_valid = 1'b0, cmp_result = 1'b0;
  logic slot_clear, field_req, capture, cmp_req, done, err;
  logic [1:0] field_angle, capture_slot;
  logic [2:0] cmp_pair, data_out;

  always #5 clk = ~clk;

  ordinal_read_seq #(.SETTLE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle),
    .slot_clear(slot_clear), .field_req(field_req), .field_angle(field_angle),
    .field_ack(field_ack), .capture(capture), .capture_slot(capture_slot),
    .cmp_req(cmp_req), .cmp_pair(cmp_pair), .cmp_valid(cmp_valid),
    .cmp_result(cmp_result), .done(done), .data_out(data_out), .err(err)
  );

  typedef struct {
    logic [2:0] data;
    logic       err;
    int         fields;
    int         cmps;
  } exp_t;
  exp_t sb[$];

  int total = 0, bad = 0;
  logic [4:0] cur_res = '0;
  int fwait = 0, cwait = 0, rd_fields = 0, rd_cmps = 0, sc = 0, all_fields = 0, dones = 0;
  bit sc_on = 0, cleared = 0, finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // analog model plus scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      field_ack = 0; cmp_valid = 0; fwait = 0; cwait = 0; sc_on = 0;
    end else begin
      if (slot_clear) begin
        cleared = 1; rd_fields = 0; rd_cmps = 0;
      end
      if (capture) begin
        check(sc == int'(settle) + 1, "R3", "settle cycles", sc, int'(settle) + 1);
        check(capture_slot == 2'(rd_fields - 1), "R2", "capture slot", capture_slot, rd_fields - 1);
        sc_on = 0;
      end else if (sc_on) sc++;
      if (done) begin
        dones++;
        if (sb.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(data_out == e.data, "R8", "data", data_out, e.data);
          check(err == e.err, "R9", "err", err, e.err);
          check(rd_fields == e.fields, "R7", "field count", rd_fields, e.fields);
          check(rd_cmps == e.cmps, "R6", "compare count", rd_cmps, e.cmps);
        end
      end
      if (field_ack) field_ack = 0;
      else if (field_req) begin
        if (fwait >= 1) begin
          field_ack = 1; fwait = 0;
          check(cleared, "R2", "clear before field", 0, 1);
          check(field_angle == 2'(rd_fields), "R2", "angle order", field_angle, rd_fields);
          rd_fields++; all_fields++; sc = 0; sc_on = 1;
        end else fwait++;
      end else fwait = 0;
      if (cmp_valid) cmp_valid = 0;
      else if (cmp_req) begin
        if (cwait >= 2) begin
          cmp_valid = 1; cwait = 0;
          cmp_result = cur_res[cmp_pair];
          check(cmp_pair == 3'(rd_cmps), "R5", "pair order", cmp_pair, rd_cmps);
          rd_cmps++;
        end else cwait++;
      end else cwait = 0;
    end
  end

  function automatic int level(input int st, input int stp);
    int t[8][3] = '{'{5,6,8}, '{4,7,7}, '{5,8,6}, '{6,7,5},
                    '{6,5,7}, '{7,4,6}, '{8,5,5}, '{7,6,4}};
    return t[st-1][stp];
  endfunction

  task automatic do_read(input logic [4:0] rv, input logic [2:0] ed,
                         input logic ee, input int nf, input int nc);
    exp_t e;
    logic [2:0] held;
    e.data = ed; e.err = ee; e.fields = nf; e.cmps = nc;
    cur_res = rv;
    sb.push_back(e);
    cleared = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (sb.size() != 0) @(negedge clk);
    held = data_out;
    @(negedge clk);
    check(!done, "R10", "done width", done, 0);
    repeat (3) @(negedge clk);
    check(data_out == held, "R10", "data held", data_out, held);
  endtask

  task automatic read_state(input int st);
    int l1, l2, l3;
    logic [4:0] rv;
    bit ext;
    l1 = level(st, 0); l2 = level(st, 1); l3 = level(st, 2);
    rv = {l2 > l3, l1 > l3, l1 > l2, l1 > 7, l1 > 4};
    ext = (l1 == 4) || (l1 == 8);
    do_read(rv, 3'(st - 1), 1'b0, ext ? 1 : 3, ext ? 2 : 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check(!field_req && !cmp_req && !capture && !slot_clear, "R1", "handshakes idle", 1, 0);
    check(!done && !err && data_out == 3'b000, "R1", "outputs cleared", data_out, 0);
    rst = 0;
    // all eight states, settle 3: R6 early exits, R7/R8 full reads
    for (int s = 1; s <= 8; s++) read_state(s);
    settle = 8'd0;
    read_state(5); read_state(2); read_state(7); read_state(3);
    settle = 8'd5;
    // R9 cyclic orderings
    do_read(5'b10101, 3'b000, 1'b1, 3, 5);
    do_read(5'b01001, 3'b000, 1'b1, 3, 5);
    // R6 low threshold wins over high
    do_read(5'b00010, 3'b001, 1'b0, 1, 2);
    // R10 next start clears err
    read_state(6);
    check(!err, "R10", "err cleared by start", err, 0);
    // R11 start while busy
    f0 = all_fields;
    begin
      exp_t e;
      e.data = 3'b011; e.err = 0; e.fields = 3; e.cmps = 5;
      cur_res = 5'b11001;
      sb.push_back(e);
      cleared = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      while (!cmp_req) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
      while (sb.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      check(all_fields - f0 == 3, "R11", "fields after busy start", all_fields - f0, 3);
    end
    // R12 reset in mid read
    begin
      exp_t e;
      int d0;
      e.data = 3'b100; e.err = 0; e.fields = 3; e.cmps = 5;
      cur_res = 5'b00101;
      sb.push_back(e);
      cleared = 0;
      d0 = dones;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      while (rd_cmps < 3) @(negedge clk);
      rst = 1;
      @(negedge clk) rst = 0;
      void'(sb.pop_front());
      @(negedge clk);
      check(!field_req && !cmp_req && !capture && !done, "R12", "idle after reset", 1, 0);
      repeat (10) @(negedge clk);
      check(dones == d0, "R12", "no done after abort", dones, d0);
      read_state(4);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule